// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns level changes on general-purpose input pins into latched interrupt requests. It has sixteen interrupt lines. Line n watches pin n of one of seven input ports, and software picks that port through a 4-bit source code per line. The chosen pin passes through a two-stage synchroniser. The block then compares the synchronised sample with the one before it to find rising and falling edges. Each line has its own enables for rising and for falling edges. An edge that is enabled latches the line's pending flag and can also give a one-clock event pulse.

Software drives the block through a small word-addressed register bus. Reads are combinational from the address, and writes take effect on the clock edge that samples the write enable. Through this bus software sets the interrupt mask and the event mask, chooses the edge types, and sets the source code of each line. Software can also force a line pending without any pin activity. A pending flag stays set until software writes a 1 to its bit. The masked pending flags are folded onto seven request outputs: five lines have an output each, and two outputs are shared by groups of lines.

Top module: `extint_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq_out` and `evt_out` are 0. Every line is therefore masked, has no edge type enabled and takes its source from port code 0.
- R2: Register 0x08 holds one rising-edge enable bit per line (bit n is line n). When the bit is 1, a 0-to-1 change on the line's selected pin sets pending bit n. The bit is still 0 at the first clock edge after the change and is 1 by the fourth.
- R3: Register 0x0C holds the falling-edge enables in the same layout, so a 1-to-0 change sets the pending bit when the bit is 1. With both enables set, either kind of change sets it. An edge of a kind whose enable is 0 leaves the pending bit unchanged.
- R4: The source of line n is pin n of the port whose code (0 to 6) is held in bits [4*(n%4)+3 : 4*(n%4)] of the word at offset 0x18 + 4*(n/4). Changes on pin n of any other port are ignored. Codes 7 to 15 select a constant 0.
- R5: Register 0x00 is the interrupt mask. A line can raise a request only while its mask bit is 1, but its pending bit is set whatever the mask.
- R6: Writing the pending register at 0x14 clears every pending bit that is written as 1. Bits written as 0 keep their value.
- R7: Writing 1 to bit n of register 0x10 sets pending bit n at the clock edge that takes the write, whatever the edge enables. Bit n of 0x10 then reads 1 until a 1 is written to pending bit n.
- R8: `evt_out[n]` is 1 for exactly one clock for each enabled edge on line n while bit n of the event mask at 0x04 is 1. The pulse is high during the cycle before the pending bit sets. It does not depend on the interrupt mask or on whether the line is already pending.
- R9: If an enabled edge and a clearing write to the same pending bit fall in the same cycle, the bit stays 1.
- R10: `irq_out[k]` for k = 0 to 4 carries masked line k. `irq_out[5]` is the OR of masked lines 5 to 9, and `irq_out[6]` is the OR of masked lines 10 to 15.
- R11: Offsets 0x00, 0x04, 0x08 and 0x0C read back what was written. Bits 31:16 of every register read 0, and unused offsets (0x28 and above) read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, sampled on the rising clock edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| port_pins | input | 112 | Pin inputs; pin n of port p is bit p*16+n |
| irq_out | output | 7 | Grouped, masked interrupt requests |
| evt_out | output | 16 | One-clock event pulse for each line |

## Verification
The bench builds the block with its default parameters: sixteen lines, seven ports, 4-bit source codes, five lines with an output of their own and a split after line 9. These values bring every source code within reach. That includes the codes 7 to 15, which select no port, and a port (code 2) far from the reset default. All three request-group shapes can be driven, so a bench-side mapping table can check every member of both shared groups. The 16-bit line count leaves bits 31:16 of every register free to show that they read as zero.

// File: rtl/extint_pkg.sv
package extint_pkg;

  // Word indices (byte offset / 4) of the register file.
  localparam int W_IMASK  = 0;
  localparam int W_EMASK  = 1;
  localparam int W_RISE   = 2;
  localparam int W_FALL   = 3;
  localparam int W_SWTRIG = 4;
  localparam int W_PEND   = 5;
  localparam int W_SRC0   = 6;

  // Four source codes share each source-select word.
  localparam int SRC_LANES = 4;
  localparam int SRC_LANE_W = 4;

  // Which request output a line is folded onto.
  function automatic int irq_slot(input int line, input int solo, input int mid_last);
    if (line < solo) return line;
    else if (line <= mid_last) return solo;
    else return solo + 1;
  endfunction

  // Word index holding the source code of a line.
  function automatic int src_word(input int line);
    return W_SRC0 + line / SRC_LANES;
  endfunction

  // Bit offset of the source code inside its word.
  function automatic int src_shift(input int line);
    return (line % SRC_LANES) * SRC_LANE_W;
  endfunction

  // Qualified edge from the current and previous synchronised samples.
  function automatic logic edge_qualify(input logic cur, input logic prev,
                                        input logic rise_en, input logic fall_en);
    return (cur & ~prev & rise_en) | (~cur & prev & fall_en);
  endfunction

endpackage

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       bus_we,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_LINES-1:0]       pend_i,
  output logic [NUM_LINES-1:0]       imask_o,
  output logic [NUM_LINES-1:0]       emask_o,
  output logic [NUM_LINES-1:0]       rise_en_o,
  output logic [NUM_LINES-1:0]       fall_en_o,
  output logic [NUM_LINES-1:0]       sw_set_o,
  output logic [NUM_LINES-1:0]       pend_clr_o,
  output logic [NUM_LINES*SEL_W-1:0] src_sel_o
);

  int word;
  always_comb word = 32'(bus_addr[ADDR_W-1:2]);

  logic [NUM_LINES-1:0] imask_q, emask_q, rise_q, fall_q, sw_q;
  logic [SEL_W-1:0]     src_q [NUM_LINES];
  logic [NUM_LINES-1:0] wlow;

  assign wlow = bus_wdata[NUM_LINES-1:0];

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[DATA_W-1:NUM_LINES], bus_addr[1:0]};

  assign sw_set_o   = (bus_we && word == W_SWTRIG) ? wlow : '0;
  assign pend_clr_o = (bus_we && word == W_PEND)   ? wlow : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      sw_q    <= '0;
    end else begin
      if (bus_we && word == W_IMASK) imask_q <= wlow;
      if (bus_we && word == W_EMASK) emask_q <= wlow;
      if (bus_we && word == W_RISE)  rise_q  <= wlow;
      if (bus_we && word == W_FALL)  fall_q  <= wlow;
      sw_q <= (sw_q | sw_set_o) & ~pend_clr_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_LINES; n++) src_q[n] <= '0;
    end else begin
      for (int n = 0; n < NUM_LINES; n++)
        if (bus_we && word == src_word(n))
          src_q[n] <= bus_wdata[src_shift(n) +: SEL_W];
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_src
    assign src_sel_o[n*SEL_W +: SEL_W] = src_q[n];
  end

  always_comb begin
    bus_rdata = '0;
    case (word)
      W_IMASK:  bus_rdata[NUM_LINES-1:0] = imask_q;
      W_EMASK:  bus_rdata[NUM_LINES-1:0] = emask_q;
      W_RISE:   bus_rdata[NUM_LINES-1:0] = rise_q;
      W_FALL:   bus_rdata[NUM_LINES-1:0] = fall_q;
      W_SWTRIG: bus_rdata[NUM_LINES-1:0] = sw_q;
      W_PEND:   bus_rdata[NUM_LINES-1:0] = pend_i;
      default: begin
        for (int n = 0; n < NUM_LINES; n++)
          if (word == src_word(n)) bus_rdata[src_shift(n) +: SEL_W] = src_q[n];
      end
    endcase
  end

  assign imask_o   = imask_q;
  assign emask_o   = emask_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;

endmodule

// File: rtl/extint_line.sv
module extint_line
  import extint_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int SEL_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] pins_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 rise_en_i,
  input  logic                 fall_en_i,
  input  logic                 sw_set_i,
  input  logic                 clr_i,
  output logic                 hit_o,
  output logic                 pend_o
);

  // Port select; codes past the last port give a constant 0.
  logic src;
  always_comb begin
    src = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (sel_i == SEL_W'(p)) src = pins_i[p];
  end

  // meta -> synced -> previous
  logic meta_q, sync_q, prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= src;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign hit_o = edge_qualify(sync_q, prev_q, rise_en_i, fall_en_i);

  // Setting takes priority over a clearing write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pend_o <= 1'b0;
    else if (hit_o || sw_set_i)  pend_o <= 1'b1;
    else if (clr_i)              pend_o <= 1'b0;
  end

endmodule

// File: rtl/extint_irq_map.sv
module extint_irq_map
  import extint_pkg::*;
#(
  parameter int NUM_LINES  = 16,
  parameter int SOLO_LINES = 5,
  parameter int MID_LAST   = 9,
  parameter int NUM_IRQ    = SOLO_LINES + 2
) (
  input  logic [NUM_LINES-1:0] req_i,
  output logic [NUM_IRQ-1:0]   irq_o
);

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_out
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int l = 0; l < NUM_LINES; l++)
        if (irq_slot(l, SOLO_LINES, MID_LAST) == k) acc = acc | req_i[l];
    end
    assign irq_o[k] = acc;
  end

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_LINES  = 16,
  parameter int NUM_PORTS  = 7,
  parameter int SEL_W      = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int SOLO_LINES = 5,
  parameter int MID_LAST   = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic                           bus_we,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
  output logic [SOLO_LINES+1:0]          irq_out,
  output logic [NUM_LINES-1:0]           evt_out
);

  localparam int NUM_IRQ = SOLO_LINES + 2;

  // Named internal events, visible to the bound checker.
  logic [NUM_LINES-1:0]       imask_q, emask_q, rise_en, fall_en;
  logic [NUM_LINES-1:0]       sw_set, clr_vec, hit_vec, set_vec, pend_q;
  logic [NUM_LINES*SEL_W-1:0] src_sel;

  extint_regs #(
    .NUM_LINES(NUM_LINES), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .pend_i(pend_q),
    .imask_o(imask_q), .emask_o(emask_q),
    .rise_en_o(rise_en), .fall_en_o(fall_en),
    .sw_set_o(sw_set), .pend_clr_o(clr_vec), .src_sel_o(src_sel)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [NUM_PORTS-1:0] pins_n;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pin
      assign pins_n[p] = port_pins[p*NUM_LINES + n];
    end
    extint_line #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_line (
      .clk(clk), .rst_n(rst_n), .pins_i(pins_n),
      .sel_i(src_sel[n*SEL_W +: SEL_W]),
      .rise_en_i(rise_en[n]), .fall_en_i(fall_en[n]),
      .sw_set_i(sw_set[n]), .clr_i(clr_vec[n]),
      .hit_o(hit_vec[n]), .pend_o(pend_q[n])
    );
  end

  assign set_vec = hit_vec | sw_set;
  assign evt_out = hit_vec & emask_q;

  extint_irq_map #(
    .NUM_LINES(NUM_LINES), .SOLO_LINES(SOLO_LINES),
    .MID_LAST(MID_LAST), .NUM_IRQ(NUM_IRQ)
  ) u_map (
    .req_i(pend_q & imask_q),
    .irq_o(irq_out)
  );

endmodule

// File: rtl/extint_chk.sv
module extint_chk #(
  parameter int NUM_LINES = 16,
  parameter int NUM_IRQ   = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] set_vec,
  input logic [NUM_LINES-1:0] clr_vec,
  input logic [NUM_LINES-1:0] imask_q,
  input logic [NUM_LINES-1:0] evt_out,
  input logic [NUM_IRQ-1:0]   irq_out
);

  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((pend_q ^ $past(pend_q)) & ~$past(set_vec | clr_vec)) == '0));

  // R5
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & imask_q) == '0) |-> (irq_out == '0));

  // R8
  evt_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_out) |=> ((pend_q & $past(evt_out)) == $past(evt_out)));

endmodule

bind extint_ctrl extint_chk #(.NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .set_vec(set_vec),
  .clr_vec(clr_vec), .imask_q(imask_q), .evt_out(evt_out), .irq_out(irq_out)
);

// File: tb/tb_extint_ctrl.sv
module tb_extint_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;
  localparam int NP = 7;
  localparam int NIRQ = 7;
  localparam int K_RD = 0, K_IRQ = 1, K_EVT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic we = 1'b0;
  logic [NP*NL-1:0] pins = '0;
  logic [31:0] rdata;
  logic [NIRQ-1:0] irq;
  logic [NL-1:0] evt;

  always #(CLK_PERIOD/2) clk = ~clk;

  extint_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .port_pins(pins),
    .irq_out(irq), .evt_out(evt)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int pushed = 0, popped = 0;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // Monitor: pops expected items and compares with what the design shows.
  initial begin
    item_t it;
    logic [31:0] act;
    forever begin
      wait (pushed != popped);
      it = sb_q.pop_front();
      if (it.kind == K_RD)       act = rdata;
      else if (it.kind == K_IRQ) act = 32'(irq);
      else                       act = 32'(evt);
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
      popped++;
    end
  end

  // Driver side of the scoreboard.
  task automatic push_exp(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    #1;
    sb_q.push_back(it);
    pushed++;
    wait (popped == pushed);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk_reg(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    push_exp(K_RD, exp, tag);
  endtask

  // Read now, without moving to the next negedge.
  task automatic chk_reg_now(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    push_exp(K_RD, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input int port, input int line, input logic v);
    @(negedge clk);
    pins[port*NL + line] = v;
  endtask

  // Independent restatement of the request grouping.
  function automatic logic [NIRQ-1:0] group_of(input logic [NL-1:0] masked);
    logic [NIRQ-1:0] g;
    g = '0;
    for (int l = 0; l < NL; l++) begin
      case (l)
        0, 1, 2, 3, 4:     g[l] = g[l] | masked[l];
        5, 6, 7, 8, 9:     g[5] = g[5] | masked[l];
        default:           g[6] = g[6] | masked[l];
      endcase
    end
    return g;
  endfunction

  // Change a pin and watch the event output around the expected pulse.
  task automatic edge_watch(input int port, input int line, input logic v,
                            input logic [NL-1:0] exp_pulse, input string tag);
    @(negedge clk);
    pins[port*NL + line] = v;
    @(negedge clk);
    push_exp(K_EVT, 32'h0, {tag, " before pulse"});
    @(negedge clk);
    push_exp(K_EVT, 32'(exp_pulse), {tag, " pulse"});
    @(negedge clk);
    push_exp(K_EVT, 32'h0, {tag, " after pulse"});
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_reg(8'h00, 32'h0, "R1 imask reset");
    chk_reg(8'h08, 32'h0, "R1 rise reset");
    chk_reg(8'h14, 32'h0, "R1 pend reset");
    chk_reg(8'h18, 32'h0, "R1 src reset");
    push_exp(K_IRQ, 32'h0, "R1 irq reset");
    push_exp(K_EVT, 32'h0, "R1 evt reset");

    // R11 readback
    wr(8'h00, 32'hFFFF_FFFF);
    chk_reg(8'h00, 32'h0000_FFFF, "R11 imask upper bits zero");
    wr(8'h04, 32'h1234_ABCD);
    chk_reg(8'h04, 32'h0000_ABCD, "R11 emask readback");
    wr(8'h0C, 32'h0000_5A5A);
    chk_reg(8'h0C, 32'h0000_5A5A, "R11 fall readback");
    wr(8'h24, 32'hFFFF_FFFF);
    chk_reg(8'h24, 32'h0000_FFFF, "R11 src word upper bits zero");
    chk_reg(8'h28, 32'h0, "R11 unused offset");
    chk_reg(8'h3C, 32'h0, "R11 unused offset high");
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h0C, 0); wr(8'h24, 0);

    // R2 rising edge on line 0, port A
    wr(8'h08, 32'h1);
    set_pin(0, 0, 1'b1);
    chk_reg(8'h14, 32'h0, "R2 not yet pending after one clock");
    idle(3);
    chk_reg(8'h14, 32'h1, "R2 rising edge sets pending");
    set_pin(0, 0, 1'b0);
    idle(4);
    wr(8'h14, 32'hFFFF);
    chk_reg(8'h14, 32'h0, "R2 falling edge ignored with rise only");

    // R3 falling only on line 1
    wr(8'h08, 0);
    wr(8'h0C, 32'h2);
    set_pin(0, 1, 1'b1);
    idle(4);
    chk_reg(8'h14, 32'h0, "R3 rising ignored with fall only");
    set_pin(0, 1, 1'b0);
    idle(4);
    chk_reg(8'h14, 32'h2, "R3 falling edge sets pending");
    wr(8'h14, 32'hFFFF);
    // both edges on line 2
    wr(8'h08, 32'h4);
    wr(8'h0C, 32'h4);
    set_pin(0, 2, 1'b1);
    idle(4);
    chk_reg(8'h14, 32'h4, "R3 both enabled rising");
    wr(8'h14, 32'hFFFF);
    set_pin(0, 2, 1'b0);
    idle(4);
    chk_reg(8'h14, 32'h4, "R3 both enabled falling");

    // R6 write-one-to-clear
    wr(8'h14, 32'h0);
    chk_reg(8'h14, 32'h4, "R6 writing 0 keeps pending");
    wr(8'h14, 32'hFFFF_FFFB);
    chk_reg(8'h14, 32'h4, "R6 other bits written 1 leave bit 2");
    wr(8'h14, 32'h4);
    chk_reg(8'h14, 32'h0, "R6 writing 1 clears");
    wr(8'h08, 0); wr(8'h0C, 0);

    // R4 source select: line 3 from port C (code 2)
    wr(8'h18, 32'h0000_2000);
    chk_reg(8'h18, 32'h0000_2000, "R4 src readback");
    wr(8'h08, 32'h8);
    set_pin(0, 3, 1'b1);
    idle(4);
    chk_reg(8'h14, 32'h0, "R4 unselected port ignored");
    set_pin(2, 3, 1'b1);
    idle(4);
    chk_reg(8'h14, 32'h8, "R4 selected port edge");
    wr(8'h14, 32'hFFFF);
    wr(8'h18, 32'h0000_9000);
    for (int p = 0; p < NP; p++) pins[p*NL + 3] = 1'b1;
    idle(4);
    chk_reg(8'h14, 32'h0, "R4 code 9 selects constant 0");
    for (int p = 0; p < NP; p++) pins[p*NL + 3] = 1'b0;
    idle(4);
    wr(8'h18, 0);
    wr(8'h08, 0);

    // R7 software trigger, R5 mask
    wr(8'h10, 32'h10);
    chk_reg_now(8'h14, 32'h10, "R7 software trigger sets pending");
    chk_reg(8'h10, 32'h10, "R7 software bit reads 1");
    push_exp(K_IRQ, 32'h0, "R5 masked line raises no request");
    wr(8'h00, 32'h10);
    push_exp(K_IRQ, 32'h10, "R5 unmasked line raises request");
    wr(8'h14, 32'h10);
    chk_reg(8'h14, 32'h0, "R7 pending cleared");
    chk_reg(8'h10, 32'h0, "R7 software bit follows pending clear");
    push_exp(K_IRQ, 32'h0, "R5 no request after clear");

    // R10 grouping
    wr(8'h00, 32'hFFFF);
    wr(8'h10, 32'h0080);
    push_exp(K_IRQ, 32'(group_of(16'h0080)), "R10 line 7 on shared output");
    wr(8'h14, 32'hFFFF);
    wr(8'h10, 32'h1000);
    push_exp(K_IRQ, 32'(group_of(16'h1000)), "R10 line 12 on shared output");
    wr(8'h14, 32'hFFFF);
    wr(8'h10, 32'h8203);
    push_exp(K_IRQ, 32'(group_of(16'h8203)), "R10 mixed lines");
    wr(8'h00, 32'h0200);
    push_exp(K_IRQ, 32'(group_of(16'h0200)), "R10 R5 partial mask");
    wr(8'h14, 32'hFFFF);
    wr(8'h00, 0);

    // R8 event pulse
    wr(8'h04, 32'h0020);
    wr(8'h08, 32'h0020);
    edge_watch(0, 5, 1'b1, 16'h0020, "R8 rising with event mask");
    chk_reg(8'h14, 32'h0020, "R8 pending after event");
    edge_watch(0, 5, 1'b0, 16'h0000, "R8 disabled falling edge");
    edge_watch(0, 5, 1'b1, 16'h0020, "R8 pulse while already pending");
    wr(8'h04, 0);
    set_pin(0, 5, 1'b0);
    idle(3);
    edge_watch(0, 5, 1'b1, 16'h0000, "R8 event mask off");
    wr(8'h14, 32'hFFFF);
    set_pin(0, 5, 1'b0);
    wr(8'h08, 0);

    // R9 set wins over same-cycle clear
    wr(8'h08, 32'h0040);
    wr(8'h10, 32'h0040);
    @(negedge clk);
    pins[0*NL + 6] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    addr = 8'h14; wdata = 32'h0040; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk_reg_now(8'h14, 32'h0040, "R9 edge and clear together keep pending");
    chk_reg(8'h10, 32'h0, "R9 software bit cleared by the write");
    wr(8'h14, 32'h0040);
    chk_reg_now(8'h14, 32'h0, "R9 plain clear");

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule